// File: doc/BRIEF.md
# Trap Entry and Delegation Unit

This unit commits the architectural side effects of taking a trap in a processor with four privilege levels: user (0), supervisor (1), hypervisor (2) and machine (3). A trap request arrives in one cycle with a cause word, the PC of the faulting instruction and, optionally, a faulting address. On the next clock edge the unit updates the target mode's saved registers and the status fields, redirects the PC and sets the new privilege. It also raises the pulses that neighbouring logic needs: one to flush address-translation caches and one to drop a pending load reservation.

The unit chooses between supervisor and machine handling with two delegation masks, one for exceptions and one for interrupts. The top bit of the cause word selects the mask. A software breakpoint can bypass normal handling and enter debug mode when the breakpoint-enable bit for the current privilege is set. While debug mode is active, every other trap only redirects the PC to a fixed debug exception address. A load port lets the trap-return logic set the privilege and interrupt enables and leave debug mode.

Top module: `trap_entry`

## Requirements
- R1: After reset: privilege is machine (3), `pc_tgt` equals `RST_VEC`, every saved register and status field is zero, debug mode is off and every pulse output is low.
- R2: When bit XLEN-1 of the cause is 1, the interrupt mask `int_deleg` is used and the index is the cause with that bit cleared. Otherwise the exception mask `exc_deleg` is used and the index is the whole cause.
- R3: A normal trap goes to supervisor (privilege 1) only when the current privilege is 0 or 1, the index is below XLEN and the mask bit at that index is 1. In every other case it goes to machine (privilege 3).
- R4: Supervisor entry does all of the following: `pc_tgt`=`svec`, `scause`=cause, `sepc`=epc, `st_spie`=`st_ie[old privilege]`, `st_spp`=bit 0 of the old privilege, and `st_ie[1]` cleared. The machine registers and `st_mpie`/`st_mpp` are left unchanged.
- R5: Machine entry does all of the following: `pc_tgt`=`mvec`, `mcause`=cause, `mepc`=epc, `st_mpie`=`st_ie[old privilege]`, `st_mpp`=old privilege, and `st_ie[3]` cleared. The supervisor registers and `st_spie`/`st_spp` are left unchanged.
- R6: The target mode's bad-address register takes `trap_addr` only when `trap_has_addr` is 1. Otherwise it keeps its value.
- R7: A cause exactly equal to `BP_CAUSE` (3), with `dbg_bp_en[current privilege]` set, enters debug mode. This holds even when debug mode is already active. Debug entry sets `dbg_cause`=1, `dbg_prv`=old privilege, `dpc`=epc, privilege=3 and `pc_tgt`=`DBG_ROM`. No other register changes and no reservation pulse is raised.
- R8: While `dbg_cause` is nonzero, a trap that is not diverted by R7 only sets `pc_tgt`=`DBG_EXC`. Privilege, saved registers and status stay unchanged, and neither the flush pulse nor the reservation pulse is raised.
- R9: `resv_clr` is high for exactly the one cycle after each normal (non-debug) trap entry.
- R10: `tlb_flush` is high for exactly the one cycle after every privilege write: normal trap entry, debug entry or a load.
- R11: `pc_set` is high for the one cycle after each accepted trap. All updates of that trap are visible in that same cycle.
- R12: A load (`ld_valid`) sets the privilege to `ld_prv` and `st_ie` to `ld_ie`, and clears `dbg_cause`. If a trap is requested in the same cycle, the trap takes effect and the load is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trap_valid | input | 1 | Trap request, accepted in the same cycle |
| trap_cause | input | XLEN | Cause word; top bit set means interrupt |
| trap_epc | input | XLEN | PC of the trapping instruction |
| trap_has_addr | input | 1 | Trap carries a faulting address |
| trap_addr | input | XLEN | Faulting address |
| exc_deleg | input | XLEN | Exception delegation mask |
| int_deleg | input | XLEN | Interrupt delegation mask |
| svec | input | XLEN | Supervisor trap vector |
| mvec | input | XLEN | Machine trap vector |
| dbg_bp_en | input | 4 | Breakpoint-to-debug enable, indexed by privilege |
| ld_valid | input | 1 | Load privilege and enables, leave debug |
| ld_prv | input | 2 | Privilege to load |
| ld_ie | input | 4 | Interrupt enables to load, indexed by privilege |
| prv | output | 2 | Current privilege |
| pc_set | output | 1 | One-cycle redirect pulse |
| pc_tgt | output | XLEN | Redirect target |
| tlb_flush | output | 1 | One-cycle pulse after a privilege write |
| resv_clr | output | 1 | One-cycle pulse to drop the load reservation |
| st_ie | output | 4 | Interrupt enables, indexed by privilege |
| st_spie | output | 1 | Supervisor previous interrupt enable |
| st_spp | output | 1 | Supervisor previous privilege |
| st_mpie | output | 1 | Machine previous interrupt enable |
| st_mpp | output | 2 | Machine previous privilege |
| sepc | output | XLEN | Supervisor exception PC |
| scause | output | XLEN | Supervisor cause |
| sbad | output | XLEN | Supervisor bad address |
| mepc | output | XLEN | Machine exception PC |
| mcause | output | XLEN | Machine cause |
| mbad | output | XLEN | Machine bad address |
| dbg_cause | output | 3 | Debug cause, nonzero while in debug |
| dbg_prv | output | 2 | Privilege at debug entry |
| dpc | output | XLEN | Debug PC |

## Verification
The assertions assume that `ld_prv` is always a valid level and that `trap_valid` is never held while the unit is being reset. The bench follows both assumptions, because it only drives the inputs one cycle after reset is released. Before each trap, the bench uses the load port to place the unit at a known privilege and enable pattern. It then sweeps every cause of an 8-bit configuration from each privilege, under two delegation-mask pairs that differ in every relevant position. Debug behaviour is exercised in separate sequences, and each one ends with a load that returns the unit to a known state.

// File: rtl/trap_entry.sv
module trap_entry #(
  parameter int XLEN = 32,
  parameter logic [XLEN-1:0] RST_VEC = '0,
  parameter logic [XLEN-1:0] DBG_ROM = XLEN'(32'h800),
  parameter logic [XLEN-1:0] DBG_EXC = XLEN'(32'h808),
  parameter logic [XLEN-1:0] BP_CAUSE = XLEN'(3)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            trap_valid,
  input  logic [XLEN-1:0] trap_cause,
  input  logic [XLEN-1:0] trap_epc,
  input  logic            trap_has_addr,
  input  logic [XLEN-1:0] trap_addr,
  input  logic [XLEN-1:0] exc_deleg,
  input  logic [XLEN-1:0] int_deleg,
  input  logic [XLEN-1:0] svec,
  input  logic [XLEN-1:0] mvec,
  input  logic [3:0]      dbg_bp_en,
  input  logic            ld_valid,
  input  logic [1:0]      ld_prv,
  input  logic [3:0]      ld_ie,
  output logic [1:0]      prv,
  output logic            pc_set,
  output logic [XLEN-1:0] pc_tgt,
  output logic            tlb_flush,
  output logic            resv_clr,
  output logic [3:0]      st_ie,
  output logic            st_spie,
  output logic            st_spp,
  output logic            st_mpie,
  output logic [1:0]      st_mpp,
  output logic [XLEN-1:0] sepc,
  output logic [XLEN-1:0] scause,
  output logic [XLEN-1:0] sbad,
  output logic [XLEN-1:0] mepc,
  output logic [XLEN-1:0] mcause,
  output logic [XLEN-1:0] mbad,
  output logic [2:0]      dbg_cause,
  output logic [1:0]      dbg_prv,
  output logic [XLEN-1:0] dpc
);
  localparam int IW = $clog2(XLEN);
  localparam logic [2:0] SWBP = 3'd1;

  logic            is_irq, idx_ok, deleg_bit, to_s, bp_hit, in_dbg;
  logic            take_dbg, take_dexc, take_norm;
  logic [XLEN-1:0] mask;
  logic [IW-1:0]   idx_lo;

  assign is_irq    = trap_cause[XLEN-1];
  assign mask      = is_irq ? int_deleg : exc_deleg;
  assign idx_ok    = ~|trap_cause[XLEN-2:IW];
  assign idx_lo    = trap_cause[IW-1:0];
  assign deleg_bit = idx_ok & mask[idx_lo];
  assign to_s      = (prv <= 2'd1) & deleg_bit;
  assign bp_hit    = (trap_cause == BP_CAUSE) & dbg_bp_en[prv];
  assign in_dbg    = dbg_cause != 3'd0;
  assign take_dbg  = trap_valid & bp_hit;
  assign take_dexc = trap_valid & ~bp_hit & in_dbg;
  assign take_norm = trap_valid & ~bp_hit & ~in_dbg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prv       <= 2'd3;
      pc_tgt    <= RST_VEC;
      pc_set    <= 1'b0;
      tlb_flush <= 1'b0;
      resv_clr  <= 1'b0;
      st_ie     <= '0;
      st_spie   <= 1'b0;
      st_spp    <= 1'b0;
      st_mpie   <= 1'b0;
      st_mpp    <= '0;
      sepc      <= '0;
      scause    <= '0;
      sbad      <= '0;
      mepc      <= '0;
      mcause    <= '0;
      mbad      <= '0;
      dbg_cause <= '0;
      dbg_prv   <= '0;
      dpc       <= '0;
    end else begin
      pc_set    <= trap_valid;
      tlb_flush <= take_dbg | take_norm | (ld_valid & ~trap_valid);
      resv_clr  <= take_norm;
      if (take_dbg) begin
        dbg_cause <= SWBP;
        dbg_prv   <= prv;
        dpc       <= trap_epc;
        prv       <= 2'd3;
        pc_tgt    <= DBG_ROM;
      end else if (take_dexc) begin
        pc_tgt <= DBG_EXC;
      end else if (take_norm && to_s) begin
        pc_tgt   <= svec;
        scause   <= trap_cause;
        sepc     <= trap_epc;
        if (trap_has_addr) sbad <= trap_addr;
        st_spie  <= st_ie[prv];
        st_spp   <= prv[0];
        st_ie[1] <= 1'b0;
        prv      <= 2'd1;
      end else if (take_norm) begin
        pc_tgt   <= mvec;
        mcause   <= trap_cause;
        mepc     <= trap_epc;
        if (trap_has_addr) mbad <= trap_addr;
        st_mpie  <= st_ie[prv];
        st_mpp   <= prv;
        st_ie[3] <= 1'b0;
        prv      <= 2'd3;
      end else if (ld_valid) begin
        prv       <= ld_prv;
        st_ie     <= ld_ie;
        dbg_cause <= '0;
      end
    end
  end

  // R3
  trap_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resv_clr |-> (prv == 2'd1 || prv == 2'd3));
  // R9
  resv_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resv_clr |-> $past(trap_valid));
  // R11
  redirect_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pc_set |-> $past(trap_valid));
  // R7
  dbg_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dbg_cause != 3'd0) |-> (prv == 2'd3 && pc_tgt == DBG_ROM));
  // R5
  m_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_valid && prv == 2'd3) |=> prv == 2'd3);
  // R4
  s_ie_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (resv_clr && prv == 2'd1) |-> !st_ie[1]);
  // R8
  dexc_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_set && pc_tgt == DBG_EXC && !tlb_flush) |-> (!resv_clr && $stable(prv)));
endmodule

// File: tb/sim_trap_entry.sv
module sim_trap_entry;
  localparam int XLEN = 8;
  localparam logic [7:0] RV = 8'h10, ROM = 8'h80, DEX = 8'h84, SV = 8'h40, MV = 8'h20;

  logic clk = 0, rst_n = 0;
  logic trap_valid = 0, trap_has_addr = 0, ld_valid = 0;
  logic [7:0] trap_cause = 0, trap_epc = 0, trap_addr = 0;
  logic [7:0] exc_deleg = 0, int_deleg = 0;
  logic [7:0] svec = SV, mvec = MV;
  logic [3:0] dbg_bp_en = 0, ld_ie = 0;
  logic [1:0] ld_prv = 0;
  logic [1:0] prv, st_mpp, dbg_prv;
  logic pc_set, tlb_flush, resv_clr, st_spie, st_spp, st_mpie;
  logic [3:0] st_ie;
  logic [7:0] pc_tgt, sepc, scause, sbad, mepc, mcause, mbad, dpc;
  logic [2:0] dbg_cause;

  trap_entry #(.XLEN(XLEN), .RST_VEC(RV), .DBG_ROM(ROM), .DBG_EXC(DEX), .BP_CAUSE(8'd3)) u0 (
    .clk(clk), .rst_n(rst_n), .trap_valid(trap_valid), .trap_cause(trap_cause),
    .trap_epc(trap_epc), .trap_has_addr(trap_has_addr), .trap_addr(trap_addr),
    .exc_deleg(exc_deleg), .int_deleg(int_deleg), .svec(svec), .mvec(mvec),
    .dbg_bp_en(dbg_bp_en), .ld_valid(ld_valid), .ld_prv(ld_prv), .ld_ie(ld_ie),
    .prv(prv), .pc_set(pc_set), .pc_tgt(pc_tgt), .tlb_flush(tlb_flush), .resv_clr(resv_clr),
    .st_ie(st_ie), .st_spie(st_spie), .st_spp(st_spp), .st_mpie(st_mpie), .st_mpp(st_mpp),
    .sepc(sepc), .scause(scause), .sbad(sbad), .mepc(mepc), .mcause(mcause), .mbad(mbad),
    .dbg_cause(dbg_cause), .dbg_prv(dbg_prv), .dpc(dpc));

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;

  logic [1:0] e_prv = 3, e_mpp = 0, e_dprv = 0;
  logic [3:0] e_ie = 0;
  logic e_spie = 0, e_spp = 0, e_mpie = 0, e_pcset = 0, e_flush = 0, e_resv = 0;
  logic [7:0] e_pc = RV, e_sepc = 0, e_scause = 0, e_sbad = 0, e_mepc = 0, e_mcause = 0, e_mbad = 0, e_dpc = 0;
  logic [2:0] e_dc = 0;

  task automatic chk(string req, string nm, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, nm, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    chk("R3", {tag, " prv"}, prv, e_prv);
    chk("R11", {tag, " pc_tgt"}, pc_tgt, e_pc);
    chk("R11", {tag, " pc_set"}, pc_set, e_pcset);
    chk("R10", {tag, " tlb_flush"}, tlb_flush, e_flush);
    chk("R9", {tag, " resv_clr"}, resv_clr, e_resv);
    chk("R4", {tag, " s regs"}, {sepc, scause, st_spie, st_spp}, {e_sepc, e_scause, e_spie, e_spp});
    chk("R5", {tag, " m regs"}, {mepc, mcause, st_mpie, st_mpp}, {e_mepc, e_mcause, e_mpie, e_mpp});
    chk("R6", {tag, " bad"}, {sbad, mbad}, {e_sbad, e_mbad});
    chk("R12", {tag, " ie"}, st_ie, e_ie);
    chk("R7", {tag, " dbg"}, {dbg_cause, dbg_prv, dpc}, {e_dc, e_dprv, e_dpc});
  endtask

  function automatic void model_trap(logic [7:0] c, logic [7:0] e, logic [7:0] a, logic h);
    logic [7:0] m;
    int ix;
    bit s;
    e_pcset = 1; e_flush = 0; e_resv = 0;
    if (c == 8'd3 && dbg_bp_en[e_prv]) begin
      e_dc = 1; e_dprv = e_prv; e_dpc = e; e_prv = 3; e_pc = ROM; e_flush = 1;
    end else if (e_dc != 0) begin
      e_pc = DEX;
    end else begin
      m = c[7] ? int_deleg : exc_deleg;   // R2
      ix = int'(c[6:0]);
      s = (e_prv <= 1) && (ix < 8) && m[ix[2:0]];
      e_flush = 1; e_resv = 1;
      if (s) begin
        e_pc = svec; e_scause = c; e_sepc = e; if (h) e_sbad = a;
        e_spie = e_ie[e_prv]; e_spp = e_prv[0]; e_ie[1] = 0; e_prv = 1;
      end else begin
        e_pc = mvec; e_mcause = c; e_mepc = e; if (h) e_mbad = a;
        e_mpie = e_ie[e_prv]; e_mpp = e_prv; e_ie[3] = 0; e_prv = 3;
      end
    end
  endfunction

  task automatic do_ld(logic [1:0] p, logic [3:0] v);
    @(negedge clk);
    ld_valid = 1; ld_prv = p; ld_ie = v;
    @(negedge clk);
    ld_valid = 0;
    e_prv = p; e_ie = v; e_dc = 0; e_flush = 1; e_resv = 0; e_pcset = 0;
    check_all("load R12");
  endtask

  task automatic do_trap(logic [7:0] c, logic [7:0] e, logic [7:0] a, logic h, string tag);
    @(negedge clk);
    trap_valid = 1; trap_cause = c; trap_epc = e; trap_addr = a; trap_has_addr = h;
    @(negedge clk);
    trap_valid = 0;
    model_trap(c, e, a, h);
    check_all(tag);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check_all("reset R1");
    rst_n = 1;
    @(negedge clk);
    check_all("post-reset R1");

    // R2 R3 R4 R5 R6: full cause sweep from every privilege
    exc_deleg = 8'b1010_1101; int_deleg = 8'b0110_0010;
    for (int p = 0; p < 4; p++)
      for (int c = 0; c < 256; c++) begin
        do_ld(2'(p), 4'(c) ^ 4'(p * 5));
        do_trap(8'(c), 8'(c) ^ 8'h5A, ~8'(c), c[0], "sweep R2");
      end
    exc_deleg = 8'b0101_0010; int_deleg = 8'b1001_1101;
    for (int p = 0; p < 2; p++)
      for (int c = 0; c < 256; c++) begin
        do_ld(2'(p), 4'hF);
        do_trap(8'(c), 8'(c) + 8'h11, 8'(c) ^ 8'hC3, ~c[1], "swapped R3");
      end

    // R7 R8: breakpoint diversion per privilege
    dbg_bp_en = 4'b0101; exc_deleg = 8'hFF; int_deleg = 8'hFF;
    for (int p = 0; p < 4; p++) begin
      do_ld(2'(p), 4'hA);
      do_trap(8'd3, 8'h33 + 8'(p), 8'h77, 1, "bp R7");
      do_trap(8'd5, 8'h44, 8'h55, 1, "in-debug R8");
      do_trap(8'h83, 8'h45, 8'h56, 1, "irq3 not bp R7");
    end
    // R7: re-entry while already in debug from privilege 0 then machine
    do_ld(2'd0, 4'h1);
    do_trap(8'd3, 8'h60, 8'h00, 0, "bp enter R7");
    dbg_bp_en = 4'b1000;
    do_trap(8'd3, 8'h61, 8'h00, 0, "bp reenter R7");

    // R12: trap wins over a simultaneous load
    do_ld(2'd0, 4'h3);
    @(negedge clk);
    trap_valid = 1; trap_cause = 8'd2; trap_epc = 8'h9C; trap_has_addr = 0;
    ld_valid = 1; ld_prv = 2'd3; ld_ie = 4'hF;
    @(negedge clk);
    trap_valid = 0; ld_valid = 0;
    model_trap(8'd2, 8'h9C, 8'h00, 0);
    check_all("trap over load R12");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule